// File: doc/BRIEF.md
# Banked GPIO and Pad Source Selector

This block owns 52 general-purpose pads and decides, pad by pad, which source drives each one. Software programs it through a synchronous register port with byte addresses and 32-bit data. Each pad is driven by one of four sources: a group function, the LED function, its own alternate function, or plain GPIO. In plain GPIO mode the pad takes its level from a data register and its direction from a direction register.

The pads fall into two 32-bit banks. The bank that holds the upper pads sits 4 bytes below the lower bank, for both direction and data. Several select registers choose the source:

- A register selects the LED function for the lowest 24 pads.
- A mode register selects the alternate function for pads 0 to 31.
- A control register handles pads 32 to 51. Its polarity is inverted: a 0 hands the pad to its alternate function.
- A base-mode register claims whole fixed pad groups at once, and it overrides every per-pad choice.

Pad input levels pass through a two-flop synchronizer before software reads them.

Top module: `pad_mux_ctrl`

## Requirements
- R1: After reset every pad has pad_oe low. The control register at 0x1C reads 0x000FFFFF. Every other register reads 0.
- R2: The direction register at 0x04 holds pads 0–31 in bits 0–31. The one at 0x00 holds pads 32–51 in bits 0–19. A 1 makes the pad an output. A pad in GPIO mode drives pad_out from its data bit and pad_oe from its direction bit.
- R3: A write to 0x0C sets the data bits of pads 0–31, and a write to 0x08 sets pads 32–51 in bits 0–19. A read of these addresses returns pad_in, synchronized, with a latency of two clock edges.
- R4: Bits 0–23 of the LED register at 0x10 route led_in[p] to pad p with pad_oe high. Bits 24–31 read 0.
- R5: A 1 in bit p of the mode register at 0x18 hands pad p (0–31) to alt_out[p] and alt_oe[p].
- R6: A 0 in bit p-32 of the control register at 0x1C hands pad p (32–51) to alt_out[p] and alt_oe[p]. A 1 keeps the pad as GPIO.
- R7: A set bit in the base-mode register at 0x38 hands every pad of its group to grp_out and grp_oe. The groups are:
  - bit 2: pads 2–7 and 24–31;
  - bit 4: pad 35;
  - bit 5: pads 8–9;
  - bit 6: pads 10–11;
  - bit 7: pads 12–13;
  - bit 8: pads 24–25;
  - bit 9: pads 26–27.

  All other bits of this register read 0.
- R8: Pads 24–27 are claimed when either of their two base-mode bits is set.
- R9: For each pad the source priority is group, then LED, then mode or control, then GPIO.
- R10: Reads of unmapped addresses return 0. Bits 20–31 of the bank at 0x00 and of the bank at 0x08 read 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | 52 | Pad input levels |
| pad_out | output | 52 | Pad output values |
| pad_oe | output | 52 | Pad output enables |
| grp_out | input | 52 | Group function output values |
| grp_oe | input | 52 | Group function output enables |
| led_in | input | 24 | LED function values for pads 0–23 |
| alt_out | input | 52 | Per-pad alternate function output values |
| alt_oe | input | 52 | Per-pad alternate function output enables |

## Verification
The bench sets each base-mode bit on its own and checks that exactly the pads of that group switch to the group source. A wrong group table would move a pad that should stay, or leave one that should move. The shared pads 24–27 are tested with each of their two bits, so a design that demanded both bits would fail there.

The bench also checks the following:
- Bank addressing: swapped bank addresses would drive the upper pads from the lower word.
- The inverted control polarity: getting it wrong would hand pads 32–51 to their alternate function straight out of reset.
- Source priority, using random full configurations.
- Synchronizer latency.
- That reserved bits and unmapped addresses read zero.

// File: rtl/pad_mux_ctrl.sv
module pad_mux_ctrl #(
  parameter int NUM_PADS = 52,
  parameter int LED_PADS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic [NUM_PADS-1:0] grp_out,
  input  logic [NUM_PADS-1:0] grp_oe,
  input  logic [LED_PADS-1:0] led_in,
  input  logic [NUM_PADS-1:0] alt_out,
  input  logic [NUM_PADS-1:0] alt_oe
);
  localparam int HI_PADS = NUM_PADS - 32;
  localparam logic [7:0] A_DIR_HI = 8'h00, A_DIR_LO = 8'h04;
  localparam logic [7:0] A_DAT_HI = 8'h08, A_DAT_LO = 8'h0C;
  localparam logic [7:0] A_LED = 8'h10, A_MODE = 8'h18, A_CTRL = 8'h1C, A_BASE = 8'h38;
  localparam logic [31:0] BASE_MASK = 32'h0000_03F4;

  logic [NUM_PADS-1:0] dir_q, dat_q, sync1_q, sync2_q, claim;
  logic [LED_PADS-1:0] led_q;
  logic [31:0]         mode_q, base_q;
  logic [HI_PADS-1:0]  ctrl_q;

  function automatic logic [31:0] grp_bits(int p);
    logic [31:0] m;
    m = '0;
    if ((p >= 2 && p <= 7) || (p >= 24 && p <= 31)) m[2] = 1'b1;
    if (p == 35)                                    m[4] = 1'b1;
    if (p == 8  || p == 9)                          m[5] = 1'b1;
    if (p == 10 || p == 11)                         m[6] = 1'b1;
    if (p == 12 || p == 13)                         m[7] = 1'b1;
    if (p == 24 || p == 25)                         m[8] = 1'b1;
    if (p == 26 || p == 27)                         m[9] = 1'b1;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dat_q   <= '0;
      led_q   <= '0;
      mode_q  <= '0;
      ctrl_q  <= '1;
      base_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (reg_wr) begin
        case (reg_addr)
          A_DIR_LO: dir_q[31:0]          <= reg_wdata;
          A_DIR_HI: dir_q[NUM_PADS-1:32] <= reg_wdata[HI_PADS-1:0];
          A_DAT_LO: dat_q[31:0]          <= reg_wdata;
          A_DAT_HI: dat_q[NUM_PADS-1:32] <= reg_wdata[HI_PADS-1:0];
          A_LED:    led_q                <= reg_wdata[LED_PADS-1:0];
          A_MODE:   mode_q               <= reg_wdata;
          A_CTRL:   ctrl_q               <= reg_wdata[HI_PADS-1:0];
          A_BASE:   base_q               <= reg_wdata & BASE_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DIR_LO: reg_rdata                = dir_q[31:0];
      A_DIR_HI: reg_rdata[HI_PADS-1:0]   = dir_q[NUM_PADS-1:32];
      A_DAT_LO: reg_rdata                = sync2_q[31:0];
      A_DAT_HI: reg_rdata[HI_PADS-1:0]   = sync2_q[NUM_PADS-1:32];
      A_LED:    reg_rdata[LED_PADS-1:0]  = led_q;
      A_MODE:   reg_rdata                = mode_q;
      A_CTRL:   reg_rdata[HI_PADS-1:0]   = ctrl_q;
      A_BASE:   reg_rdata                = base_q;
      default: ;
    endcase
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic led_sel, alt_sel;
    assign claim[p] = |(base_q & grp_bits(p));
    if (p < LED_PADS) begin : g_led
      assign led_sel = led_q[p];
    end else begin : g_noled
      assign led_sel = 1'b0;
    end
    if (p < 32) begin : g_mode
      assign alt_sel = mode_q[p];
    end else begin : g_ctrl
      assign alt_sel = ~ctrl_q[p-32];
    end
    assign pad_oe[p]  = claim[p] ? grp_oe[p]  : led_sel ? 1'b1      : alt_sel ? alt_oe[p]  : dir_q[p];
    assign pad_out[p] = claim[p] ? grp_out[p] : led_sel ? led_in[p] : alt_sel ? alt_out[p] : dat_q[p];
  end
endmodule

// File: rtl/pad_mux_ctrl_chk.sv
module pad_mux_ctrl_chk #(
  parameter int NUM_PADS = 52,
  parameter int LED_PADS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          reg_addr,
  input logic                reg_wr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic [NUM_PADS-1:0] pad_in,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] grp_out,
  input logic [NUM_PADS-1:0] grp_oe,
  input logic [NUM_PADS-1:0] dir_q,
  input logic [LED_PADS-1:0] led_q,
  input logic [31:0]         base_q
);
  localparam int HI_PADS = NUM_PADS - 32;
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R2
  dir_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 8'h04 |=> dir_q[31:0] == $past(reg_wdata));
  // R3
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == 2'd3 && reg_addr == 8'h0C |-> reg_rdata == $past(pad_in[31:0], 2));
  // R4
  led_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_q[0] |-> pad_oe[0]);
  // R7
  nand_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[2] |-> pad_oe[2] == grp_oe[2] && pad_out[2] == grp_out[2]);
  // R8
  shared_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[8] |-> pad_oe[24] == grp_oe[24] && pad_out[24] == grp_out[24]);
  // R10
  hi_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h00 || reg_addr == 8'h08 |-> reg_rdata[31:HI_PADS] == '0);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h14 |-> reg_rdata == 32'h0);
endmodule

bind pad_mux_ctrl pad_mux_ctrl_chk #(.NUM_PADS(NUM_PADS), .LED_PADS(LED_PADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .grp_out(grp_out), .grp_oe(grp_oe),
  .dir_q(dir_q), .led_q(led_q), .base_q(base_q)
);

// File: tb/tb_pad_mux_ctrl.sv
module tb_pad_mux_ctrl;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [51:0] pad_in = 0, pad_out, pad_oe, grp_out = 0, grp_oe = 0, alt_out = 0, alt_oe = 0;
  logic [23:0] led_in = 0;
  int errors = 0, checks = 0;

  logic [51:0] m_dir, m_dat;
  logic [23:0] m_led;
  logic [31:0] m_mode, m_base;
  logic [19:0] m_ctrl;

  always #5 clk = ~clk;

  pad_mux_ctrl dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .pad_in,
    .pad_out, .pad_oe, .grp_out, .grp_oe, .led_in, .alt_out, .alt_oe);

  task automatic fail_or_pass(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    case (a)
      8'h00: m_dir[51:32] = d[19:0];
      8'h04: m_dir[31:0]  = d;
      8'h08: m_dat[51:32] = d[19:0];
      8'h0C: m_dat[31:0]  = d;
      8'h10: m_led  = d[23:0];
      8'h18: m_mode = d;
      8'h1C: m_ctrl = d[19:0];
      8'h38: m_base = d & 32'h3F4;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return {12'b0, m_dir[51:32]};
      8'h04: return m_dir[31:0];
      8'h08: return {12'b0, pad_in[51:32]};
      8'h0C: return pad_in[31:0];
      8'h10: return {8'b0, m_led};
      8'h18: return m_mode;
      8'h1C: return {12'b0, m_ctrl};
      8'h38: return m_base;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [7:0] a, input string req);
    reg_addr = a; #1;
    fail_or_pass(reg_rdata == exp_rd(a), req, {32'b0, reg_rdata}, {32'b0, exp_rd(a)});
  endtask

  task automatic rd_all(input string req);
    foreach (addrs[i]) rd(addrs[i], req);
  endtask
  logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18, 8'h1C, 8'h38};

  function automatic bit grp_hit(int p);
    bit h = 0;
    if (m_base[2] && ((p >= 2 && p <= 7) || (p >= 24 && p <= 31))) h = 1;
    if (m_base[4] && p == 35) h = 1;
    if (m_base[5] && (p == 8 || p == 9)) h = 1;
    if (m_base[6] && (p == 10 || p == 11)) h = 1;
    if (m_base[7] && (p == 12 || p == 13)) h = 1;
    if (m_base[8] && (p == 24 || p == 25)) h = 1;
    if (m_base[9] && (p == 26 || p == 27)) h = 1;
    return h;
  endfunction

  task automatic chk_pads(input string req);
    logic [51:0] eo, ev;
    for (int p = 0; p < 52; p++) begin
      if (grp_hit(p))                                        begin eo[p] = grp_oe[p]; ev[p] = grp_out[p]; end
      else if (p < 24 && m_led[p])                           begin eo[p] = 1'b1;      ev[p] = led_in[p];  end
      else if ((p < 32 && m_mode[p]) || (p >= 32 && !m_ctrl[p-32])) begin eo[p] = alt_oe[p]; ev[p] = alt_out[p]; end
      else                                                   begin eo[p] = m_dir[p];  ev[p] = m_dat[p];   end
    end
    #1;
    fail_or_pass(pad_oe == eo, {req, " oe"}, {12'b0, pad_oe}, {12'b0, eo});
    fail_or_pass(pad_out == ev, {req, " out"}, {12'b0, pad_out}, {12'b0, ev});
  endtask

  task automatic rnd_inputs();
    grp_out = {$urandom, $urandom}; grp_oe = {$urandom, $urandom};
    alt_out = {$urandom, $urandom}; alt_oe = {$urandom, $urandom};
    led_in = 24'($urandom);
  endtask

  initial begin
    #1ms;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_dir = 0; m_dat = 0; m_led = 0; m_mode = 0; m_base = 0; m_ctrl = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_pads("R1");
    rd_all("R1");
    // R2 direction and data banks
    rnd_inputs();
    wr(8'h04, 32'hA5A5_5A5A); wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h1234_5678); wr(8'h08, 32'hFFF5_A3C1);
    rd(8'h04, "R2"); rd(8'h00, "R2");
    chk_pads("R2");
    wr(8'h00, 32'h0000_0F0F); wr(8'h04, 32'h0);
    rd(8'h00, "R2"); chk_pads("R2");
    // R3 synchronized input reads
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); pad_in = {$urandom, $urandom};
      repeat (3) @(negedge clk);
      rd(8'h0C, "R3"); rd(8'h08, "R3");
    end
    // R3 latency: one edge after a change the old value still shows
    @(negedge clk); pad_in = 52'h0; repeat (3) @(negedge clk);
    pad_in = '1; @(negedge clk); reg_addr = 8'h0C; #1;
    fail_or_pass(reg_rdata == 32'h0, "R3 latency1", {32'b0, reg_rdata}, 64'h0);
    @(negedge clk); #1;
    fail_or_pass(reg_rdata == 32'hFFFF_FFFF, "R3 latency2", {32'b0, reg_rdata}, 64'hFFFF_FFFF);
    // R4 LED
    wr(8'h04, '1); wr(8'h00, '1);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R4"); chk_pads("R4");
    wr(8'h10, 32'h00C3_0F55); rnd_inputs(); chk_pads("R4");
    wr(8'h10, 0);
    // R5 mode
    wr(8'h18, 32'hF0F0_3C3C); rnd_inputs(); rd(8'h18, "R5"); chk_pads("R5");
    // R6 control, inverted polarity
    wr(8'h1C, 32'h0000_0000); rnd_inputs(); rd(8'h1C, "R6"); chk_pads("R6");
    wr(8'h1C, 32'hFFFA_5A5A); rnd_inputs(); rd(8'h1C, "R6"); chk_pads("R6");
    wr(8'h18, 0); wr(8'h1C, 0);
    // R7 base-mode, one bit at a time
    for (int b = 0; b < 32; b++) begin
      wr(8'h38, 32'h1 << b); rnd_inputs();
      rd(8'h38, "R7"); chk_pads("R7");
    end
    // R8 shared pads 24-27 with each of their bits
    wr(8'h38, 32'h100); grp_oe = '1; grp_out = '1; alt_oe = '0; alt_out = '0; chk_pads("R8");
    wr(8'h38, 32'h200); chk_pads("R8");
    wr(8'h38, 32'h304); chk_pads("R8");
    wr(8'h38, 32'h004); chk_pads("R8");
    // R9 priority over random full configurations
    for (int i = 0; i < 40; i++) begin
      wr(8'h04, $urandom); wr(8'h00, $urandom); wr(8'h0C, $urandom); wr(8'h08, $urandom);
      wr(8'h10, $urandom); wr(8'h18, $urandom); wr(8'h1C, $urandom); wr(8'h38, $urandom);
      rnd_inputs(); chk_pads("R9");
    end
    // R10 unmapped reads and ignored writes
    rd(8'h14, "R10"); rd(8'h20, "R10"); rd(8'h3C, "R10"); rd(8'hFC, "R10");
    wr(8'h14, '1); wr(8'h34, '1); wr(8'h3C, '1); wr(8'hFF, '1);
    rd_all("R10"); chk_pads("R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule